// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a small serial EEPROM that sits on a three-wire bus made up of a select line, a serial clock and a data-in line, plus a data-out line. It is meant to stand in for a real memory part when a host controller is under test. All pins are sampled in the system clock domain. A command is shifted in on serial clock rising edges while the select line is high. The array holds 1024 words of 8 bits in registers. It is not cleared by reset, so stored contents survive a reset as they would in a non-volatile part.

Programming commands are write word, erase word, erase all and write all. They do not act when they are shifted in. Each one is armed when its last bit arrives and is launched only when select is dropped before the next serial clock rising edge. It then runs for a fixed number of system clock cycles with no serial clock needed. The host can raise select again and watch the data-out line to see whether the part is still busy or ready. Programming is refused until the host sends an unlock command. Reads are never refused.

Top module: `uw_eeprom_slave`

## Requirements
- R1: After reset, programming is locked. A write, erase, erase-all or write-all command starts no program cycle and changes no word until an unlock command is received. Reset leaves array contents unchanged.
- R2: An unlock command keeps programming allowed across any number of later commands. A lock command refuses programming again until the next unlock.
- R3: A read frame is a start bit 1, opcode 10, then 10 address bits sent MSB first. After the last address bit, data-out drives a 0 dummy bit. On each following serial clock rising edge it shows the next bit of the stored word, MSB first. Reads work whether programming is locked or unlocked.
- R4: A write frame is start bit 1, opcode 01, 10 address bits, then 8 data bits MSB first. It stores the data at that address when select falls in the launch window.
- R5: An erase frame is start bit 1, opcode 11, then 10 address bits. It sets the addressed word to FF and leaves every other word unchanged.
- R6: Extended frames use opcode 00, and the two top address bits pick the command: 11 unlock, 00 lock, 10 erase all, 01 write all. In an erase-all frame the low address bits are don't-care. Erase all sets every word to FF. Write all is followed by 8 data bits and stores that byte in every word, with no erase needed first.
- R7: A program cycle starts only if select falls after the last bit of the frame and before the next serial clock rising edge. If select falls earlier, or a rising edge comes first, the array is left unchanged.
- R8: When select is raised after a program cycle has started, data-out is enabled. It drives 0 for the PROG_CYCLES system clocks that the cycle lasts, then 1. Whenever select is low, data-out is not enabled.
- R9: A command sent while a program cycle is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the control state |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data or busy/ready status to the host |
| dout_en | output | 1 | Output enable for dout; low means high impedance |

## Verification
Two events can land in the same serial clock window: the select drop that launches a program cycle, and a serial clock rising edge that abandons it. The bench provokes each order separately. It drops select one data bit early, and it sends one extra serial clock pulse before dropping select. In both cases the target word is read back and must still hold its earlier value. A second overlap is a new command arriving while the busy timer is still running. The bench sends a full write during that time and then checks that the target word is unchanged.

// File: rtl/uw_eeprom_pkg.sv
package uw_eeprom_pkg;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } uw_op_e;

    typedef enum logic [1:0] {
        EX_LOCK   = 2'b00,
        EX_FILL   = 2'b01,
        EX_CLEAR  = 2'b10,
        EX_UNLOCK = 2'b11
    } uw_ext_e;

    typedef enum logic [1:0] {
        PK_WORD      = 2'd0,
        PK_ERASE     = 2'd1,
        PK_ALL_ERASE = 2'd2,
        PK_ALL_WORD  = 2'd3
    } uw_prog_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_RDLD,
        ST_READ,
        ST_ARMED,
        ST_DROP
    } uw_state_e;

    typedef struct packed {
        uw_state_e next;
        uw_prog_e  kind;
        logic      set_wen;
        logic      clr_wen;
    } uw_decode_t;

    function automatic uw_decode_t decode_cmd(input logic [1:0] op, input logic [1:0] ext);
        uw_decode_t d;
        d.next    = ST_DROP;
        d.kind    = PK_WORD;
        d.set_wen = 1'b0;
        d.clr_wen = 1'b0;
        case (op)
            OP_READ:  d.next = ST_RDLD;
            OP_WRITE: begin d.next = ST_DATA;  d.kind = PK_WORD;  end
            OP_ERASE: begin d.next = ST_ARMED; d.kind = PK_ERASE; end
            default: begin
                case (ext)
                    EX_UNLOCK: d.set_wen = 1'b1;
                    EX_LOCK:   d.clr_wen = 1'b1;
                    EX_CLEAR:  begin d.next = ST_ARMED; d.kind = PK_ALL_ERASE; end
                    default:   begin d.next = ST_DATA;  d.kind = PK_ALL_WORD;  end
                endcase
            end
        endcase
        return d;
    endfunction

    function automatic logic is_all(input uw_prog_e k);
        return (k == PK_ALL_ERASE) || (k == PK_ALL_WORD);
    endfunction

    function automatic logic is_clear(input uw_prog_e k);
        return (k == PK_ERASE) || (k == PK_ALL_ERASE);
    endfunction

endpackage

// File: rtl/uw_pin_edge.sv
module uw_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    output logic sk_rise,
    output logic cs_fall
);
    logic sk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    assign sk_rise = sk & ~sk_q & cs;
    assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/uw_busy_timer.sv
module uw_busy_timer #(
    parameter int CYC = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (go) begin
            remain <= CW'(CYC);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (rst) go |=> busy); // R8
endmodule

// File: rtl/uw_array.sv
module uw_array
    import uw_eeprom_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  uw_prog_e      kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] fill;
    logic          every;

    assign fill  = is_clear(kind) ? {DW{1'b1}} : data;
    assign every = is_all(kind);

    // Contents are deliberately not reset: they model non-volatile storage.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (go && (every || addr == AW'(i))) begin
                mem[i] <= fill;
            end
        end
    end

    assign rd_data = mem[rd_addr];

    AST_ERASE_ONES: assert property (@(posedge clk) disable iff (rst)
        (go && kind == PK_ERASE) |=> (mem[$past(addr)] == {DW{1'b1}})); // R5
    AST_WORD_STORED: assert property (@(posedge clk) disable iff (rst)
        (go && kind == PK_WORD) |=> (mem[$past(addr)] == $past(data))); // R4
endmodule

// File: rtl/uw_ctrl.sv
module uw_ctrl
    import uw_eeprom_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          di,
    input  logic          sk_rise,
    input  logic          cs_fall,
    input  logic          busy,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          prog_go,
    output uw_prog_e      prog_kind,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          dout,
    output logic          dout_en
);
    localparam int HDR_BITS = AW + 2;
    localparam int MAX_BITS = (HDR_BITS > DW) ? HDR_BITS : DW;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    uw_state_e             state;
    logic [HDR_BITS-1:0]   hdr_sr;
    logic [HDR_BITS-1:0]   hdr_nxt;
    logic [CNT_W-1:0]      bit_cnt;
    logic [DW-1:0]         data_sr;
    logic [DW:0]           rd_sr;
    logic                  wen;
    logic                  status_ph;
    uw_prog_e              kind_q;
    logic [AW-1:0]         addr_q;
    uw_decode_t            dec;

    assign hdr_nxt = {hdr_sr[HDR_BITS-2:0], di};
    assign dec     = decode_cmd(hdr_nxt[HDR_BITS-1 -: 2], hdr_nxt[AW-1 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hdr_sr    <= '0;
            bit_cnt   <= '0;
            data_sr   <= '0;
            rd_sr     <= '0;
            wen       <= 1'b0;
            status_ph <= 1'b0;
            kind_q    <= PK_WORD;
            addr_q    <= '0;
            prog_go   <= 1'b0;
        end else begin
            prog_go <= 1'b0;
            if (cs_fall) begin
                state <= ST_IDLE;
                if (!busy) status_ph <= 1'b0;
                if (state == ST_ARMED && wen) begin
                    prog_go   <= 1'b1;
                    status_ph <= 1'b1;
                end
            end else if (state == ST_RDLD) begin
                rd_sr <= {1'b0, rd_data};
                state <= ST_READ;
            end else if (sk_rise) begin
                case (state)
                    ST_IDLE: begin
                        if (!busy && di) begin
                            state     <= ST_HDR;
                            bit_cnt   <= '0;
                            status_ph <= 1'b0;
                        end
                    end
                    ST_HDR: begin
                        hdr_sr  <= hdr_nxt;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_W'(HDR_BITS - 1)) begin
                            state   <= dec.next;
                            kind_q  <= dec.kind;
                            addr_q  <= hdr_nxt[AW-1:0];
                            bit_cnt <= '0;
                            if (dec.set_wen) wen <= 1'b1;
                            if (dec.clr_wen) wen <= 1'b0;
                        end
                    end
                    ST_DATA: begin
                        data_sr <= {data_sr[DW-2:0], di};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_W'(DW - 1)) begin
                            state <= ST_ARMED;
                        end
                    end
                    ST_READ:  rd_sr <= {rd_sr[DW-1:0], 1'b0};
                    ST_ARMED: state <= ST_DROP;
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr   = addr_q;
    assign prog_kind = kind_q;
    assign prog_addr = addr_q;
    assign prog_data = data_sr;

    assign dout_en = cs & (status_ph | (state == ST_RDLD) | (state == ST_READ));
    assign dout    = status_ph ? ~busy : ((state == ST_READ) & rd_sr[DW]);

    AST_GO_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst) prog_go |-> wen); // R2
    AST_GO_AFTER_CSFALL: assert property (@(posedge clk) disable iff (rst) prog_go |-> $past(cs_fall)); // R7
    AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) prog_go |-> !busy); // R9
endmodule

// File: rtl/uw_eeprom_slave.sv
module uw_eeprom_slave
    import uw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_en
);
    logic              sk_rise;
    logic              cs_fall;
    logic              busy;
    logic              prog_go;
    uw_prog_e          prog_kind;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    uw_pin_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .sk      (sk),
        .sk_rise (sk_rise),
        .cs_fall (cs_fall)
    );

    uw_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs        (cs),
        .di        (di),
        .sk_rise   (sk_rise),
        .cs_fall   (cs_fall),
        .busy      (busy),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .prog_go   (prog_go),
        .prog_kind (prog_kind),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    uw_busy_timer #(.CYC(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (prog_go),
        .busy (busy)
    );

    uw_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .go      (prog_go),
        .kind    (prog_kind),
        .addr    (prog_addr),
        .data    (prog_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/uw_eeprom_slave_bench.sv
module uw_eeprom_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs  = 1'b0;
    logic sk  = 1'b0;
    logic di  = 1'b0;
    logic dout;
    logic dout_en;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uw_eeprom_slave #(.ADDR_W(10), .DATA_W(8), .PROG_CYCLES(PROG)) u_uw_eeprom_slave (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        di = b;
        tick(2);
        sk = 1'b1;
        tick(2);
        sk = 1'b0;
    endtask

    task automatic sel_on();
        cs = 1'b1;
        tick(2);
    endtask

    task automatic sel_off();
        cs = 1'b0;
        tick(3);
    endtask

    task automatic settle();
        tick(PROG + 10);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [9:0] a);
        clk_bit(1'b1);
        clk_bit(op[1]);
        clk_bit(op[0]);
        for (int i = 9; i >= 0; i--) clk_bit(a[i]);
    endtask

    task automatic send_byte(input logic [7:0] d, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) clk_bit(d[i]);
    endtask

    task automatic write_ns(input logic [9:0] a, input logic [7:0] d);
        sel_on();
        send_hdr(2'b01, a);
        send_byte(d, 8);
        sel_off();
    endtask

    task automatic do_write(input logic [9:0] a, input logic [7:0] d);
        write_ns(a, d);
        settle();
    endtask

    task automatic do_erase(input logic [9:0] a);
        sel_on();
        send_hdr(2'b11, a);
        sel_off();
        settle();
    endtask

    task automatic do_ext(input logic [1:0] code);
        sel_on();
        send_hdr(2'b00, {code, 8'h00});
        sel_off();
    endtask

    task automatic do_wral(input logic [7:0] d);
        sel_on();
        send_hdr(2'b00, {2'b01, 8'h00});
        send_byte(d, 8);
        sel_off();
        settle();
    endtask

    task automatic rd_check(input logic [9:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        sel_on();
        send_hdr(2'b10, a);
        tick(2);
        chk({tag, " read dout_en"}, 32'(dout_en), 32'd1);
        chk({tag, " dummy bit"}, 32'(dout), 32'd0);
        for (int i = 7; i >= 0; i--) begin
            sk = 1'b1;
            tick(2);
            got[i] = dout;
            sk = 1'b0;
            tick(2);
        end
        sel_off();
        chk({tag, " read data"}, 32'(got), 32'(exp));
    endtask

    task automatic no_status(input string tag);
        cs = 1'b1;
        tick(3);
        chk(tag, 32'(dout_en), 32'd0);
        sel_off();
    endtask

    task automatic t_reset();
        chk("R8 reset dout_en", 32'(dout_en), 32'd0);
        no_status("R8 no status after reset");
    endtask

    task automatic t_locked();
        write_ns(10'd3, 8'h3C);
        no_status("R1 locked write starts no cycle");
        do_ext(2'b11);
        do_write(10'd3, 8'h3C);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(2);
        write_ns(10'd3, 8'hC3);
        no_status("R1 locked after reset");
        do_ext(2'b11);
        rd_check(10'd3, 8'h3C, "R1 word kept");
    endtask

    task automatic t_write_read();
        do_write(10'd0, 8'hA5);
        do_write(10'd1023, 8'h5A);
        do_write(10'd512, 8'h0F);
        rd_check(10'd0, 8'hA5, "R4 addr 0");
        rd_check(10'd1023, 8'h5A, "R4 addr 1023");
        rd_check(10'd512, 8'h0F, "R3 addr 512");
    endtask

    task automatic t_lock_again();
        do_ext(2'b00);
        do_write(10'd0, 8'h11);
        rd_check(10'd0, 8'hA5, "R2 lock blocks, R3 read while locked");
        do_ext(2'b11);
        do_write(10'd0, 8'h22);
        do_write(10'd1, 8'h33);
        rd_check(10'd0, 8'h22, "R2 unlocked first");
        rd_check(10'd1, 8'h33, "R2 stays unlocked");
    endtask

    task automatic t_erase();
        do_write(10'd7, 8'h00);
        do_write(10'd8, 8'h81);
        do_erase(10'd7);
        rd_check(10'd7, 8'hFF, "R5 erased word");
        rd_check(10'd8, 8'h81, "R5 neighbour kept");
    endtask

    task automatic t_all();
        do_ext(2'b10);
        settle();
        rd_check(10'd0, 8'hFF, "R6 erase all 0");
        rd_check(10'd300, 8'hFF, "R6 erase all 300");
        rd_check(10'd1023, 8'hFF, "R6 erase all 1023");
        do_write(10'd5, 8'h00);
        do_wral(8'h96);
        rd_check(10'd5, 8'h96, "R6 write all over 00");
        rd_check(10'd0, 8'h96, "R6 write all 0");
        rd_check(10'd1023, 8'h96, "R6 write all 1023");
    endtask

    task automatic t_window();
        do_write(10'd9, 8'h5A);
        sel_on();
        send_hdr(2'b01, 10'd9);
        send_byte(8'hA5, 7);
        sel_off();
        settle();
        rd_check(10'd9, 8'h5A, "R7 early drop");
        sel_on();
        send_hdr(2'b01, 10'd9);
        send_byte(8'hA5, 8);
        clk_bit(1'b0);
        sel_off();
        settle();
        rd_check(10'd9, 8'h5A, "R7 late drop write");
        sel_on();
        send_hdr(2'b11, 10'd9);
        clk_bit(1'b0);
        sel_off();
        settle();
        rd_check(10'd9, 8'h5A, "R7 late drop erase");
    endtask

    task automatic t_status();
        write_ns(10'd10, 8'h77);
        sel_on();
        chk("R8 status enabled", 32'(dout_en), 32'd1);
        chk("R8 busy low early", 32'(dout), 32'd0);
        tick(PROG / 2);
        chk("R8 busy low mid", 32'(dout), 32'd0);
        tick(PROG / 2 + 10);
        chk("R8 ready high", 32'(dout), 32'd1);
        cs = 1'b0;
        tick(2);
        chk("R8 hi-z when deselected", 32'(dout_en), 32'd0);
        tick(1);
        no_status("R8 status cleared after ready");
        rd_check(10'd10, 8'h77, "R8 word stored");
    endtask

    task automatic t_busy_ignore();
        do_write(10'd11, 8'h11);
        write_ns(10'd12, 8'h44);
        write_ns(10'd11, 8'hEE);
        settle();
        rd_check(10'd11, 8'h11, "R9 busy command ignored");
        rd_check(10'd12, 8'h44, "R9 first write done");
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_locked();
        t_write_read();
        t_lock_again();
        t_erase();
        t_all();
        t_window();
        t_status();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule